// File: doc/BRIEF.md
# Panel Bias Rail Sequencer

This controller brings up the four bias supplies of a display panel one after another and takes them away in the opposite order. The rails are the analog supply (stage 0), the positive gate supply (stage 1), the negative gate supply (stage 2) and the common-electrode supply (stage 3). Each stage raises an enable output and then waits for that rail's power-good input. The power-good input is synchronised and debounced before the controller acts on it. The next stage begins only after a programmable delay. Delays, timeouts and debounce windows are counted in microsecond ticks, which are derived from the system clock.

Each stage has a watchdog on its power-good input. The analog supply stage may try again up to two times, and the start delay grows with each try. The gate and common-electrode stages get a single attempt. When a stage fails for good, the controller latches a fault and records which stage failed. It drives either a soft-discharge command (analog stage) or a clamp command (gate stages). It then removes every rail that is already enabled, in reverse order. While the fault is latched, new power-up requests have no effect until software clears the fault.

Top module: `bias_seq`

## Requirements
- R1: A one-cycle `upReq` pulse, accepted only in the idle state with no latched fault, raises `railEn[0]`, `railEn[1]`, `railEn[2]` and `railEn[3]` in that order, one bit at a time. `railsUp` goes high once `pgRaw[3]` has been debounced good. `railEn` is always a low-filled thermometer code (0000, 0001, 0011, 0111, 1111).
- R2: `railEn[0]` rises no earlier than `cfgDelay[0]`-1 ticks after `upReq`. For k>0, `railEn[k]` rises only after stage k-1's power-good has been debounced good, and then no earlier than `cfgDelay[k]` ticks after `railEn[k-1]` rose.
- R3: Power-good is sampled on each tick, after a two-flop synchroniser. Its debounced value changes only after the raw level has differed from it on `cfgDebounce[s]`+1 consecutive ticks. A shorter pulse is ignored and does not advance the sequence.
- R4: A `downReq` pulse, accepted only while `railsUp` is high, drops `railsUp` and then clears `railEn[3]`, `railEn[2]`, `railEn[1]` and `railEn[0]` in that order. Each next drop comes no earlier than `cfgDelay` of the stage just dropped, minus one tick.
- R5: If stage 0's power-good is not debounced good within `cfgTimeout[0]` ticks of its enable, the controller sets `pgTimeoutFlag[0]`, drops `railEn[0]` and retries. The start delay of the retries is `cfgDelay[0]`×2 and then ×4. At most two retries are made, so stage 0 is enabled at most three times per request.
- R6: After the last stage-0 timeout, `faultLatched`=1, `faultStage`=0, `softDischarge`=1 and `clampEngage`=0, and all rails are off.
- R7: A timeout on stage k in 1..3 sets `pgTimeoutFlag[k]` with no retry. It latches the fault with `faultStage`=k and `clampEngage`=1, then clears `railEn[k]` down to `railEn[0]` in order.
- R8: While `faultLatched` is high, `upReq` leaves `railEn` at 0000. A `faultClr` pulse clears `faultLatched`, `faultStage`, `pgTimeoutFlag`, `softDischarge` and `clampEngage`.
- R9: `pgThrSel[s]` equals `cfgThr[s]` while `railEn[s]` is high and is zero while that rail is off. `softDischarge` and `clampEngage` are never high together.
- R10: After reset all enables, flags, fault outputs, `railsUp` and `pgThrSel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | One-cycle power-up request |
| downReq | input | 1 | One-cycle power-down request |
| faultClr | input | 1 | One-cycle fault latch clear |
| cfgDelay | input | 4×TIME_W | Per-stage start/stop delay in ticks |
| cfgTimeout | input | 4×TIME_W | Per-stage power-good timeout in ticks |
| cfgDebounce | input | 4×DEB_W | Per-stage debounce length in ticks |
| cfgThr | input | 4×THR_W | Per-stage power-good threshold selection |
| pgRaw | input | 4 | Raw power-good per rail (asynchronous) |
| railEn | output | 4 | Rail enable commands, bit = stage |
| pgThrSel | output | 4×THR_W | Threshold selection driven to each enabled rail's monitor |
| railsUp | output | 1 | All four rails up and good |
| pgTimeoutFlag | output | 4 | Per-stage power-good timeout flags |
| faultLatched | output | 1 | Fault latch state |
| faultStage | output | 2 | Index of the stage that caused the fault |
| softDischarge | output | 1 | Soft-discharge command after analog-rail failure |
| clampEngage | output | 1 | Gate/source clamp command after gate-rail failure |

## Verification
The bench drives the sequencer against a rail model in five configurations. With all rails healthy, it checks order and minimum spacing on the way up and on the way down. With stage 1's power-good chattering in pulses shorter than its debounce window, it shows that noise cannot advance the sequence and that it ends in a stage-1 fault. With stage 2 dead, it separates the no-retry clamp path and the partial reverse shutdown from the full one. With stage 0 dead, it separates the three-attempt, lengthening-delay discharge path from the gate-rail path. A request issued during a latched fault, followed by a clear and a fresh healthy bring-up, shows that the latch blocks the sequence and that clearing it restores normal operation.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;
  localparam int N_STAGE = 4;
  localparam int STG_W = 2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP_DLY,
    ST_UP_WAIT,
    ST_ON,
    ST_DN_DROP,
    ST_DN_DLY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             cntLoad;    // reload the shared tick counter
    logic             useTimeout; // load timeout instead of delay
    logic [STG_W-1:0] stage;      // stage whose config is loaded
    logic [1:0]       stretch;    // left shift applied to the delay (retries)
  } seqStrobe_t;
endpackage

// File: rtl/bias_seq_dp.sv
module bias_seq_dp import bias_seq_pkg::*; #(
  parameter int TICK_DIV = 125,
  parameter int TIME_W   = 18,
  parameter int DEB_W    = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  seqStrobe_t                      stb,
  input  logic [N_STAGE-1:0][TIME_W-1:0]  cfgDelay,
  input  logic [N_STAGE-1:0][TIME_W-1:0]  cfgTimeout,
  input  logic [N_STAGE-1:0][DEB_W-1:0]   cfgDebounce,
  input  logic [N_STAGE-1:0]              pgRaw,
  output logic                            cntZero,
  output logic [N_STAGE-1:0]              pgDeb
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = TIME_W + 2;

  // microsecond tick
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + DIV_W'(1);
  end

  // shared delay / timeout counter
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    if (stb.useTimeout) loadVal = {2'b00, cfgTimeout[stb.stage]};
    else                loadVal = {2'b00, cfgDelay[stb.stage]} << stb.stretch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    cnt <= '0;
    else if (stb.cntLoad)         cnt <= loadVal;
    else if (tick && cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  // synchroniser
  logic [N_STAGE-1:0] syncA, syncB;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pgRaw;
      syncB <= syncA;
    end
  end

  // per-stage debouncers
  for (genvar s = 0; s < N_STAGE; s++) begin : g_deb
    logic             deb;
    logic [DEB_W-1:0] run;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        deb <= 1'b0;
        run <= '0;
      end else if (tick) begin
        if (syncB[s] == deb) begin
          run <= '0;
        end else if (run == cfgDebounce[s]) begin
          deb <= syncB[s];
          run <= '0;
        end else begin
          run <= run + DEB_W'(1);
        end
      end
    end
    assign pgDeb[s] = deb;
  end

  // R3: debounced level moves only on a tick
  p_deb_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(pgDeb))
    else $error("debounced power-good changed off tick");

  // counter never moves without a tick or a load
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stb.cntLoad) |=> $stable(cnt))
    else $error("counter moved without tick");
endmodule

// File: rtl/bias_seq_ctrl.sv
module bias_seq_ctrl import bias_seq_pkg::*; #(
  parameter int AVDD_RETRIES = 2, // at most 3 (2-bit stretch)
  parameter int THR_W        = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           upReq,
  input  logic                           downReq,
  input  logic                           faultClr,
  input  logic                           cntZero,
  input  logic [N_STAGE-1:0]             pgDeb,
  input  logic [N_STAGE-1:0][THR_W-1:0]  cfgThr,
  output seqStrobe_t                     stb,
  output logic [N_STAGE-1:0]             railEn,
  output logic [N_STAGE-1:0][THR_W-1:0]  pgThrSel,
  output logic                           railsUp,
  output logic [N_STAGE-1:0]             pgTimeoutFlag,
  output logic                           faultLatched,
  output logic [STG_W-1:0]               faultStage,
  output logic                           softDischarge,
  output logic                           clampEngage
);
  localparam logic [STG_W-1:0] LAST = STG_W'(N_STAGE - 1);

  seqState_t          state, stateN;
  logic [STG_W-1:0]   stage, stageN;
  logic [1:0]         attempt, attemptN;
  logic [N_STAGE-1:0] railEnN, flagN;
  logic               latchN, softN, clampN;
  logic [STG_W-1:0]   fStageN;

  always_comb begin
    stateN   = state;
    stageN   = stage;
    attemptN = attempt;
    railEnN  = railEn;
    flagN    = pgTimeoutFlag;
    latchN   = faultLatched;
    fStageN  = faultStage;
    softN    = softDischarge;
    clampN   = clampEngage;
    stb       = '0;
    stb.stage = stage;

    if (faultClr) begin
      latchN  = 1'b0;
      flagN   = '0;
      fStageN = '0;
      softN   = 1'b0;
      clampN  = 1'b0;
    end

    case (state)
      ST_OFF: begin
        if (upReq && !faultLatched) begin
          stageN      = '0;
          attemptN    = '0;
          stb.cntLoad = 1'b1;
          stb.stage   = '0;
          stateN      = ST_UP_DLY;
        end
      end
      ST_UP_DLY: begin
        if (cntZero) begin
          railEnN[stage] = 1'b1;
          stb.cntLoad    = 1'b1;
          stb.useTimeout = 1'b1;
          stateN         = ST_UP_WAIT;
        end
      end
      ST_UP_WAIT: begin
        if (pgDeb[stage]) begin
          if (stage == LAST) begin
            stateN = ST_ON;
          end else begin
            stageN      = stage + STG_W'(1);
            stb.cntLoad = 1'b1;
            stb.stage   = stage + STG_W'(1);
            stateN      = ST_UP_DLY;
          end
        end else if (cntZero) begin
          flagN[stage] = 1'b1;
          if (stage == '0 && attempt < 2'(AVDD_RETRIES)) begin
            railEnN[0]  = 1'b0;
            attemptN    = attempt + 2'd1;
            stb.cntLoad = 1'b1;
            stb.stretch = attempt + 2'd1;
            stateN      = ST_UP_DLY;
          end else begin
            latchN  = 1'b1;
            fStageN = stage;
            if (stage == '0) softN  = 1'b1;
            else             clampN = 1'b1;
            stateN  = ST_DN_DROP;
          end
        end
      end
      ST_ON: begin
        if (downReq) begin
          stageN = LAST;
          stateN = ST_DN_DROP;
        end
      end
      ST_DN_DROP: begin
        railEnN[stage] = 1'b0;
        stb.cntLoad    = 1'b1;
        stateN         = ST_DN_DLY;
      end
      ST_DN_DLY: begin
        if (cntZero) begin
          if (stage == '0) begin
            stateN = ST_OFF;
          end else begin
            stageN = stage - STG_W'(1);
            stateN = ST_DN_DROP;
          end
        end
      end
      default: stateN = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_OFF;
      stage         <= '0;
      attempt       <= '0;
      railEn        <= '0;
      pgTimeoutFlag <= '0;
      faultLatched  <= 1'b0;
      faultStage    <= '0;
      softDischarge <= 1'b0;
      clampEngage   <= 1'b0;
    end else begin
      state         <= stateN;
      stage         <= stageN;
      attempt       <= attemptN;
      railEn        <= railEnN;
      pgTimeoutFlag <= flagN;
      faultLatched  <= latchN;
      faultStage    <= fStageN;
      softDischarge <= softN;
      clampEngage   <= clampN;
    end
  end

  assign railsUp = (state == ST_ON);

  for (genvar s = 0; s < N_STAGE; s++) begin : g_thr
    assign pgThrSel[s] = railEn[s] ? cfgThr[s] : '0;
  end

  // R1: enables always form a low-filled thermometer code
  p_thermo_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({1'b0, railEn} + 5'd1))
    else $error("rail enables out of order");

  // R2: a stage rises only on top of the one below it
  for (genvar s = 1; s < N_STAGE; s++) begin : g_ord
    p_order_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(railEn[s]) |-> (railEn[s-1] && !railsUp))
      else $error("stage enabled before its predecessor");
  end

  // R5: retry counter bounded
  p_retry_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    attempt <= 2'(AVDD_RETRIES))
    else $error("too many analog-rail retries");

  // R9: discharge and clamp never together
  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(softDischarge && clampEngage))
    else $error("discharge and clamp both active");

  // R8: latched fault with rails off keeps them off
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && railEn == '0 && !faultClr) |=> railEn == '0)
    else $error("rail enabled while fault latched");
endmodule

// File: rtl/bias_seq.sv
module bias_seq import bias_seq_pkg::*; #(
  parameter int TICK_DIV     = 125,
  parameter int TIME_W       = 18,
  parameter int DEB_W        = 8,
  parameter int THR_W        = 2,
  parameter int AVDD_RETRIES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     upReq,
  input  logic                     downReq,
  input  logic                     faultClr,
  input  logic [3:0][TIME_W-1:0]   cfgDelay,
  input  logic [3:0][TIME_W-1:0]   cfgTimeout,
  input  logic [3:0][DEB_W-1:0]    cfgDebounce,
  input  logic [3:0][THR_W-1:0]    cfgThr,
  input  logic [3:0]               pgRaw,
  output logic [3:0]               railEn,
  output logic [3:0][THR_W-1:0]    pgThrSel,
  output logic                     railsUp,
  output logic [3:0]               pgTimeoutFlag,
  output logic                     faultLatched,
  output logic [1:0]               faultStage,
  output logic                     softDischarge,
  output logic                     clampEngage
);
  seqStrobe_t         stb;
  logic               cntZero;
  logic [N_STAGE-1:0] pgDeb;

  bias_seq_dp #(
    .TICK_DIV (TICK_DIV),
    .TIME_W   (TIME_W),
    .DEB_W    (DEB_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfgDelay    (cfgDelay),
    .cfgTimeout  (cfgTimeout),
    .cfgDebounce (cfgDebounce),
    .pgRaw       (pgRaw),
    .cntZero     (cntZero),
    .pgDeb       (pgDeb)
  );

  bias_seq_ctrl #(
    .AVDD_RETRIES (AVDD_RETRIES),
    .THR_W        (THR_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .upReq         (upReq),
    .downReq       (downReq),
    .faultClr      (faultClr),
    .cntZero       (cntZero),
    .pgDeb         (pgDeb),
    .cfgThr        (cfgThr),
    .stb           (stb),
    .railEn        (railEn),
    .pgThrSel      (pgThrSel),
    .railsUp       (railsUp),
    .pgTimeoutFlag (pgTimeoutFlag),
    .faultLatched  (faultLatched),
    .faultStage    (faultStage),
    .softDischarge (softDischarge),
    .clampEngage   (clampEngage)
  );
endmodule

// File: tb/bias_seq_bench.sv
module bias_seq_bench;
  localparam int TICK = 4;
  localparam int TW   = 18;
  localparam int DW   = 8;
  localparam int TO   = 20;
  localparam int DEB  = 2;
  localparam int DLY [4] = '{3, 5, 2, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upReq = 1'b0, downReq = 1'b0, faultClr = 1'b0;
  logic [3:0][TW-1:0] cfgDelay, cfgTimeout;
  logic [3:0][DW-1:0] cfgDebounce;
  logic [3:0][1:0]    cfgThr;
  logic [3:0] pgRaw = 4'h0;
  logic [3:0] railEn, pgTimeoutFlag;
  logic [3:0][1:0] pgThrSel;
  logic railsUp, faultLatched, softDischarge, clampEngage;
  logic [1:0] faultStage;

  always #4 clk = ~clk; // 125 MHz

  bias_seq #(.TICK_DIV(TICK), .TIME_W(TW), .DEB_W(DW)) u_bias_seq (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq), .faultClr(faultClr),
    .cfgDelay(cfgDelay), .cfgTimeout(cfgTimeout), .cfgDebounce(cfgDebounce),
    .cfgThr(cfgThr), .pgRaw(pgRaw), .railEn(railEn), .pgThrSel(pgThrSel),
    .railsUp(railsUp), .pgTimeoutFlag(pgTimeoutFlag), .faultLatched(faultLatched),
    .faultStage(faultStage), .softDischarge(softDischarge), .clampEngage(clampEngage)
  );

  int checks = 0, fails = 0, cycle = 0, upCycle = 0;
  string curReq = "R10";
  logic [3:0] expQ[$];
  logic [3:0] healthy = 4'hF;
  bit chatter1 = 1'b0;
  bit finished = 1'b0;
  int riseAt[4], fallAt[4];
  int r0Rise[$];
  logic [3:0] prevEn = 4'h0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // rail model: power-good follows enable when healthy; stage 1 may chatter
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      pgRaw = railEn & healthy;
      if (chatter1 && railEn[1]) pgRaw[1] = ((ph % 12) < 4);
    end
  end

  // monitor: pops expected enable patterns as the design produces them
  initial forever begin
    @(negedge clk);
    cycle++;
    if (rstN && railEn !== prevEn) begin
      logic [3:0] e;
      for (int s = 0; s < 4; s++) begin
        if (railEn[s] && !prevEn[s]) begin
          riseAt[s] = cycle;
          if (s == 0) r0Rise.push_back(cycle);
        end
        if (!railEn[s] && prevEn[s]) fallAt[s] = cycle;
      end
      if (expQ.size() == 0) begin
        chk(1'b0, curReq, "unexpected railEn change", int'(railEn), int'(prevEn));
      end else begin
        e = expQ.pop_front();
        chk(railEn == e, curReq, "railEn step", int'(railEn), int'(e));
      end
      prevEn = railEn;
    end
  end

  task automatic pulseUp;
    @(negedge clk); upReq = 1'b1; upCycle = cycle;
    @(negedge clk); upReq = 1'b0;
  endtask

  task automatic pulseDown;
    @(negedge clk); downReq = 1'b1;
    @(negedge clk); downReq = 1'b0;
  endtask

  task automatic pulseClr;
    @(negedge clk); faultClr = 1'b1;
    @(negedge clk); faultClr = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expQ.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(expQ.size() == 0, req, "sequence completed, items left", expQ.size(), 0);
    repeat (60) @(negedge clk);
  endtask

  task automatic pushUp;
    expQ.push_back(4'b0001); expQ.push_back(4'b0011);
    expQ.push_back(4'b0111); expQ.push_back(4'b1111);
  endtask

  task automatic pushDown;
    expQ.push_back(4'b0111); expQ.push_back(4'b0011);
    expQ.push_back(4'b0001); expQ.push_back(4'b0000);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      cfgDelay[s]    = TW'(DLY[s]);
      cfgTimeout[s]  = TW'(TO);
      cfgDebounce[s] = DW'(DEB);
      cfgThr[s]      = 2'(s + 1) ^ 2'b10;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(railEn == 4'h0, "R10", "railEn after reset", int'(railEn), 0);
    chk(!railsUp, "R10", "railsUp after reset", int'(railsUp), 0);
    chk(pgTimeoutFlag == 4'h0, "R10", "flags after reset", int'(pgTimeoutFlag), 0);
    chk({faultLatched, softDischarge, clampEngage} == 3'b0, "R10", "fault outputs after reset",
        int'({faultLatched, softDischarge, clampEngage}), 0);
    chk(pgThrSel == '0, "R10", "pgThrSel after reset", int'(pgThrSel), 0);

    // R1/R2: healthy bring-up
    curReq = "R1";
    pushUp();
    pulseUp();
    drain("R1");
    chk(railsUp, "R1", "railsUp after full bring-up", int'(railsUp), 1);
    for (int s = 0; s < 4; s++)
      chk(pgThrSel[s] == cfgThr[s], "R9", "threshold select of enabled rail", int'(pgThrSel[s]), int'(cfgThr[s]));
    chk(riseAt[0] - upCycle >= (DLY[0] - 1) * TICK, "R2", "first enable spacing",
        riseAt[0] - upCycle, (DLY[0] - 1) * TICK);
    for (int k = 1; k < 4; k++)
      chk(riseAt[k] - riseAt[k-1] >= DLY[k] * TICK, "R2", "stage enable spacing",
          riseAt[k] - riseAt[k-1], DLY[k] * TICK);

    // R4: orderly power-down
    curReq = "R4";
    pushDown();
    pulseDown();
    drain("R4");
    chk(!railsUp, "R4", "railsUp after power-down", int'(railsUp), 0);
    for (int k = 3; k > 0; k--)
      chk(fallAt[k-1] - fallAt[k] >= (DLY[k] - 1) * TICK, "R4", "stage removal spacing",
          fallAt[k-1] - fallAt[k], (DLY[k] - 1) * TICK);
    chk(pgThrSel == '0, "R9", "threshold select with rails off", int'(pgThrSel), 0);
    chk(!faultLatched, "R4", "no fault after clean cycle", int'(faultLatched), 0);
    repeat (100) @(negedge clk);

    // R3 + R7: stage 1 power-good chatters shorter than debounce
    curReq = "R3";
    chatter1 = 1'b1;
    expQ.push_back(4'b0001); expQ.push_back(4'b0011);
    expQ.push_back(4'b0001); expQ.push_back(4'b0000);
    pulseUp();
    drain("R3");
    chk(faultLatched && faultStage == 2'd1, "R7", "fault stage after chatter timeout",
        int'(faultStage), 1);
    chk(pgTimeoutFlag == 4'b0010, "R7", "timeout flag after chatter", int'(pgTimeoutFlag), 2);
    chk(clampEngage && !softDischarge, "R7", "clamp/discharge after gate fault",
        int'({clampEngage, softDischarge}), 2);
    chatter1 = 1'b0;

    // R8: request ignored while latched
    curReq = "R8";
    pulseUp();
    repeat (300) @(negedge clk);
    chk(railEn == 4'h0, "R8", "railEn with latched fault", int'(railEn), 0);
    chk(faultLatched, "R8", "latch held", int'(faultLatched), 1);
    pulseClr();
    chk({faultLatched, clampEngage, softDischarge} == 3'b0 && pgTimeoutFlag == 4'h0,
        "R8", "fault state after clear", int'({faultLatched, clampEngage, softDischarge, pgTimeoutFlag}), 0);
    repeat (50) @(negedge clk);

    // R7: stage 2 dead, partial reverse shutdown
    curReq = "R7";
    healthy = 4'b1011;
    expQ.push_back(4'b0001); expQ.push_back(4'b0011); expQ.push_back(4'b0111);
    expQ.push_back(4'b0011); expQ.push_back(4'b0001); expQ.push_back(4'b0000);
    pulseUp();
    drain("R7");
    chk(faultLatched && faultStage == 2'd2, "R7", "fault stage for dead stage 2", int'(faultStage), 2);
    chk(pgTimeoutFlag == 4'b0100, "R7", "timeout flag stage 2", int'(pgTimeoutFlag), 4);
    chk(clampEngage, "R7", "clamp engaged", int'(clampEngage), 1);
    pulseClr();
    healthy = 4'hF;
    repeat (100) @(negedge clk);

    // R5 + R6: analog rail dead, retries with lengthening delay
    curReq = "R5";
    healthy = 4'b1110;
    r0Rise.delete();
    for (int i = 0; i < 3; i++) begin
      expQ.push_back(4'b0001);
      expQ.push_back(4'b0000);
    end
    pulseUp();
    drain("R5");
    repeat (300) @(negedge clk);
    chk(r0Rise.size() == 3, "R5", "number of stage-0 attempts", r0Rise.size(), 3);
    if (r0Rise.size() == 3) begin
      int g1, g2;
      g1 = r0Rise[1] - r0Rise[0];
      g2 = r0Rise[2] - r0Rise[1];
      chk(g2 >= g1 + 4 * TICK, "R5", "second retry gap longer", g2, g1 + 4 * TICK);
      chk(g1 >= (TO + 2 * DLY[0] - 2) * TICK, "R5", "first retry gap", g1, (TO + 2 * DLY[0] - 2) * TICK);
    end
    chk(pgTimeoutFlag == 4'b0001, "R6", "timeout flag stage 0", int'(pgTimeoutFlag), 1);
    chk(softDischarge && !clampEngage, "R6", "discharge without clamp",
        int'({softDischarge, clampEngage}), 2);
    chk(faultLatched && faultStage == 2'd0, "R6", "fault stage 0", int'({faultLatched, faultStage}), 4);
    chk(railEn == 4'h0, "R6", "rails off after analog fault", int'(railEn), 0);
    pulseClr();
    chk(!softDischarge && !faultLatched, "R8", "discharge released by clear",
        int'({softDischarge, faultLatched}), 0);
    healthy = 4'hF;
    repeat (100) @(negedge clk);

    // R1: recovery after clear
    curReq = "R1";
    pushUp();
    pulseUp();
    drain("R1");
    chk(railsUp, "R1", "railsUp after recovery", int'(railsUp), 1);
    curReq = "R4";
    pushDown();
    pulseDown();
    drain("R4");
    chk(!railsUp && railEn == 4'h0, "R4", "rails off at end", int'({railsUp, railEn}), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements act=running exp=done");
      summary();
      $finish;
    end
  end
endmodule